// File: doc/BRIEF.md
# Interlocked Byte Handshake Engine

This block is the target end of an asynchronous parallel bus that moves one byte per handshake. The bus has eight data lines and one odd parity line. A local sequencer picks the direction, pulses a start input and later receives a one-cycle completion pulse, the captured byte and a parity error flag. The engine raises a strobe (the request line) toward the initiator. The initiator answers on a reply line (the acknowledge line), which arrives asynchronously and passes through a two-flop synchronizer before the state machine uses it.

In the send direction the engine drives the data and parity lines first. It waits a programmable deskew-plus-cable-skew interval, raises the strobe and holds the data until the synchronized reply is seen. It then releases the bus and drops the strobe on the same edge. In the receive direction the engine raises the strobe and leaves the bus undriven. It captures the byte when the reply is seen and drops the strobe. In both directions the transfer ends only after the reply has fallen again, so both edges of the handshake are interlocked. An abort input, like reset, releases the bus and the strobe at the next clock edge and returns the engine to idle.

Top module: `hs_byte_engine`

## Requirements
- R1: After reset the strobe, the bus drive enable, the done pulse, the busy flag and the parity error flag are all low.
- R2: In a send, the data and parity lines are driven from the clock edge that accepts the start pulse. The strobe rises exactly SKEW_CYC cycles later (default 3).
- R3: In a send, the driven byte and the drive enable stay constant while the strobe is high. On the edge where the synchronized reply is first seen high, the drive enable and the strobe both go low.
- R4: In a receive, the strobe rises on the edge that accepts the start pulse and the bus is never driven. The byte on the bus is captured on the edge where the synchronized reply is first seen high, and on that edge the strobe goes low.
- R5: Once the strobe has dropped, the engine starts no new handshake and gives no done pulse while the reply stays high. The done pulse is one cycle wide and becomes visible three clock edges after the reply falls: two synchronizer stages, then the state register.
- R6: Whenever the bus is driven, the total count of ones over the eight data bits and the parity bit is odd.
- R7: The parity error flag is high together with the done pulse of a receive exactly when the received nine bits hold an even count of ones. The flag is low for every send.
- R8: When abort is asserted, the strobe and the drive enable are low after the next clock edge, and the engine is idle (busy low).
- R9: A start pulse given while a transfer is in progress is ignored. The transfer under way keeps its direction, its byte and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle request for a transfer, accepted only when idle |
| xfer_send | input | 1 | Direction with start: 1 = target sends, 0 = target receives |
| xfer_abort | input | 1 | Ends any transfer and releases the bus at the next edge |
| tx_byte | input | 8 | Byte to send, sampled with start |
| xfer_done | output | 1 | One-cycle pulse when a handshake has fully completed |
| rx_byte | output | 8 | Last captured byte |
| parity_err | output | 1 | High with done when a received byte fails odd parity |
| xfer_busy | output | 1 | Engine is not idle |
| bus_dat_i | input | 8 | Data lines as seen on the bus |
| bus_par_i | input | 1 | Parity line as seen on the bus |
| bus_dat_o | output | 8 | Data value to drive |
| bus_par_o | output | 1 | Parity value to drive |
| bus_oe | output | 1 | Drive enable for the data and parity lines |
| strobe_o | output | 1 | Request line toward the initiator |
| reply_i | input | 1 | Asynchronous acknowledge from the initiator |

## Verification
The bench sends and receives every byte value. It counts the exact number of cycles that the data is driven before the strobe rises, so a timer that is off by one cycle, or a strobe raised together with the data, shows up as a wrong gap. In some transfers the bench holds the reply high long after the strobe falls. An engine that ends on the strobe edge alone would then pulse done early or start the next handshake. Receives with deliberately bad parity catch an inverted or missing parity check. Stray start pulses during a transfer catch an engine that restarts or takes on a new direction. Aborts during the skew wait and during the strobe catch a bus that is released late.

// File: rtl/hs_byte_pkg.sv
package hs_byte_pkg;

    localparam int unsigned DATA_W = 8;

    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SKEW     = 3'd1,
        ST_SEND_RQ  = 3'd2,
        ST_RECV_RQ  = 3'd3,
        ST_WAIT_REL = 3'd4
    } hs_state_e;

    typedef struct packed {
        logic  oe;
        data_t dat;
        logic  par;
    } bus_drv_t;

    // Parity bit that makes the nine-bit word hold an odd number of ones.
    function automatic logic odd_parity_bit(data_t d);
        return ~(^d);
    endfunction

    // True when data plus parity hold an odd number of ones.
    function automatic logic odd_parity_ok(data_t d, logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_skew_timer.sv
module hs_skew_timer #(
    parameter int unsigned SKEW_CYC = 3,
    localparam int unsigned CW = $clog2(SKEW_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(SKEW_CYC);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(1));

    initial begin
        a_r2_skew_nonzero: assert (SKEW_CYC >= 1)
            else $error("SKEW_CYC must be at least 1");
    end
endmodule

// File: rtl/hs_rx_capture.sv
module hs_rx_capture
    import hs_byte_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  data_t dat_i,
    input  logic  par_i,
    output data_t byte_o,
    output logic  bad_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o <= '0;
            bad_o  <= 1'b0;
        end else if (cap) begin
            byte_o <= dat_i;
            bad_o  <= ~odd_parity_ok(dat_i, par_i);
        end
    end
endmodule

// File: rtl/hs_byte_engine.sv
module hs_byte_engine
    import hs_byte_pkg::*;
#(
    parameter int unsigned SKEW_CYC    = 3,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned GW = $clog2(SKEW_CYC + 2) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_start,
    input  logic             xfer_send,
    input  logic             xfer_abort,
    input  logic [DATA_W-1:0] tx_byte,
    output logic             xfer_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic             parity_err,
    output logic             xfer_busy,
    input  logic [DATA_W-1:0] bus_dat_i,
    input  logic             bus_par_i,
    output logic [DATA_W-1:0] bus_dat_o,
    output logic             bus_par_o,
    output logic             bus_oe,
    output logic             strobe_o,
    input  logic             reply_i
);
    hs_state_e state_q;
    bus_drv_t  drv_q;
    logic      strobe_q;
    logic      done_q;
    logic      dir_send_q;
    logic      reply_s;
    logic      skew_last;
    logic      timer_load;
    logic      timer_run;
    logic      cap;
    logic      rx_bad;
    logic      accept;

    // ACK resynchronization
    hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (reply_i),
        .sync_o  (reply_s)
    );

    assign accept     = (state_q == ST_IDLE) && xfer_start && !xfer_abort;
    assign timer_load = accept && xfer_send;
    assign timer_run  = (state_q == ST_SKEW);

    hs_skew_timer #(.SKEW_CYC(SKEW_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (timer_load),
        .run  (timer_run),
        .last (skew_last)
    );

    assign cap = (state_q == ST_RECV_RQ) && reply_s && !xfer_abort;

    hs_rx_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .dat_i  (bus_dat_i),
        .par_i  (bus_par_i),
        .byte_o (rx_byte),
        .bad_o  (rx_bad)
    );

    // Handshake sequencer
    always_ff @(posedge clk) begin
        if (rst || xfer_abort) begin
            state_q  <= ST_IDLE;
            strobe_q <= 1'b0;
            drv_q.oe <= 1'b0;
            done_q   <= 1'b0;
            if (rst) begin
                drv_q.dat  <= '0;
                drv_q.par  <= 1'b0;
                dir_send_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (xfer_start) begin
                        dir_send_q <= xfer_send;
                        if (xfer_send) begin
                            drv_q.oe  <= 1'b1;
                            drv_q.dat <= tx_byte;
                            drv_q.par <= odd_parity_bit(tx_byte);
                            state_q   <= ST_SKEW;
                        end else begin
                            strobe_q <= 1'b1;
                            state_q  <= ST_RECV_RQ;
                        end
                    end
                end
                ST_SKEW: begin
                    if (skew_last) begin
                        strobe_q <= 1'b1;
                        state_q  <= ST_SEND_RQ;
                    end
                end
                ST_SEND_RQ: begin
                    if (reply_s) begin
                        strobe_q <= 1'b0;
                        drv_q.oe <= 1'b0;
                        state_q  <= ST_WAIT_REL;
                    end
                end
                ST_RECV_RQ: begin
                    if (reply_s) begin
                        strobe_q <= 1'b0;
                        state_q  <= ST_WAIT_REL;
                    end
                end
                ST_WAIT_REL: begin
                    if (!reply_s) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_oe     = drv_q.oe;
    assign bus_dat_o  = drv_q.dat;
    assign bus_par_o  = drv_q.par;
    assign strobe_o   = strobe_q;
    assign xfer_done  = done_q;
    assign xfer_busy  = (state_q != ST_IDLE);
    assign parity_err = done_q && !dir_send_q && rx_bad;

    // Checker state: cycles the bus has been driven with the strobe low
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (!bus_oe) begin
            gap_q <= '0;
        end else if (!strobe_o && gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r2_skew_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(strobe_o) && bus_oe) |-> (gap_q == GW'(SKEW_CYC)));

    a_r3_hold_data: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && bus_oe && !reply_s && !xfer_abort)
            |=> (bus_oe && $stable(bus_dat_o) && $stable(bus_par_o)));

    a_r4_rx_undriven: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && !dir_send_q) |-> !bus_oe);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

    a_r5_wait_release: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_REL && reply_s) |=> (!strobe_o && !xfer_done));

    a_r6_odd_parity: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ($countones({bus_dat_o, bus_par_o}) % 2 == 1));

    a_r7_send_no_perr: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && dir_send_q) |-> !parity_err);

    a_r8_abort_release: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |=> (!strobe_o && !bus_oe && !xfer_busy));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (xfer_busy && !xfer_abort && state_q != ST_WAIT_REL)
            |=> (xfer_busy && $stable(dir_send_q)));
endmodule

// File: tb/hs_byte_engine_bench.sv
module hs_byte_engine_bench;
    localparam int SKEW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0;
    logic       xfer_send = 1'b0;
    logic       xfer_abort = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       xfer_done;
    logic [7:0] rx_byte;
    logic       parity_err;
    logic       xfer_busy;
    logic [7:0] bus_dat_i = '0;
    logic       bus_par_i = 1'b0;
    logic [7:0] bus_dat_o;
    logic       bus_par_o;
    logic       bus_oe;
    logic       strobe_o;
    logic       reply_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hs_byte_engine #(.SKEW_CYC(SKEW)) u_hs_byte_engine (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_send(xfer_send),
        .xfer_abort(xfer_abort), .tx_byte(tx_byte), .xfer_done(xfer_done),
        .rx_byte(rx_byte), .parity_err(parity_err), .xfer_busy(xfer_busy),
        .bus_dat_i(bus_dat_i), .bus_par_i(bus_par_i), .bus_dat_o(bus_dat_o),
        .bus_par_o(bus_par_o), .bus_oe(bus_oe), .strobe_o(strobe_o),
        .reply_i(reply_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_send(input logic [7:0] b, input bit stray);
        int gap;
        int n;
        @(negedge clk);
        tx_byte = b; xfer_send = 1'b1; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        gap = 0; n = 0;
        while (!strobe_o && n < 50) begin
            if (bus_oe) gap++;
            xfer_start = stray && (n == 0);
            xfer_send  = !(stray && (n == 0));
            n++;
            @(negedge clk);
        end
        xfer_start = 1'b0; xfer_send = 1'b1;
        chk(gap == SKEW, "R2 skew gap", gap, SKEW);
        if (stray) chk(gap == SKEW, "R9 stray start ignored in send", gap, SKEW);
        chk(bus_oe && bus_dat_o == b, "R2 data driven at strobe", int'(bus_dat_o), int'(b));
        chk(($countones({bus_dat_o, bus_par_o}) % 2) == 1, "R6 odd parity",
            $countones({bus_dat_o, bus_par_o}), 1);
        reply_i = 1'b1;
        n = 0;
        while (strobe_o && n < 20) begin
            chk(bus_oe && bus_dat_o == b, "R3 data held", int'(bus_dat_o), int'(b));
            n++;
            @(negedge clk);
        end
        chk(n == 3, "R3 strobe drop latency", n, 3);
        chk(!bus_oe, "R3 bus released with strobe", int'(bus_oe), 0);
        for (int k = 0; k < 4; k++) begin
            chk(!strobe_o && !xfer_done, "R5 wait reply low", int'(strobe_o | xfer_done), 0);
            @(negedge clk);
        end
        reply_i = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (k < 3) chk(!xfer_done, "R5 done not early", int'(xfer_done), 0);
            else begin
                chk(xfer_done, "R5 done after reply low", int'(xfer_done), 1);
                chk(!parity_err, "R7 no perr on send", int'(parity_err), 0);
            end
        end
        @(negedge clk);
        chk(!xfer_done && !xfer_busy, "R5 done single cycle", int'(xfer_done | xfer_busy), 0);
    endtask

    task automatic do_recv(input logic [7:0] b, input bit badpar);
        int n;
        @(negedge clk);
        xfer_send = 1'b0; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(strobe_o && !bus_oe, "R4 strobe raised, bus undriven", int'(strobe_o), 1);
        bus_dat_i = b;
        bus_par_i = ~(^b) ^ badpar;
        @(negedge clk);
        reply_i = 1'b1;
        n = 0;
        while (strobe_o && n < 20) begin
            chk(!bus_oe, "R4 bus undriven", int'(bus_oe), 0);
            n++;
            @(negedge clk);
        end
        chk(n == 3, "R4 capture latency", n, 3);
        bus_dat_i = ~b;
        bus_par_i = ~bus_par_i;
        xfer_start = 1'b1; xfer_send = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        @(negedge clk);
        chk(!strobe_o && !bus_oe && !xfer_done, "R9 start ignored while busy",
            int'(strobe_o | bus_oe | xfer_done), 0);
        reply_i = 1'b0;
        for (int k = 1; k <= 3; k++) @(negedge clk);
        chk(xfer_done, "R5 done after reply low", int'(xfer_done), 1);
        chk(rx_byte == b, "R4 captured byte", int'(rx_byte), int'(b));
        chk(parity_err == badpar, "R7 parity error flag", int'(parity_err), int'(badpar));
        @(negedge clk);
        chk(!xfer_done && !parity_err, "R7 flag only with done", int'(parity_err), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!strobe_o && !bus_oe && !xfer_done && !xfer_busy && !parity_err,
            "R1 reset state", int'({strobe_o, bus_oe, xfer_done, xfer_busy, parity_err}), 0);

        // R8: abort during receive strobe
        xfer_send = 1'b0; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(strobe_o, "R8 setup strobe", int'(strobe_o), 1);
        xfer_abort = 1'b1;
        @(negedge clk);
        xfer_abort = 1'b0;
        chk(!strobe_o && !xfer_busy, "R8 abort in receive", int'(strobe_o | xfer_busy), 0);

        // R8: abort during send skew wait
        tx_byte = 8'h5A; xfer_send = 1'b1; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(bus_oe, "R8 setup drive", int'(bus_oe), 1);
        xfer_abort = 1'b1;
        @(negedge clk);
        xfer_abort = 1'b0;
        chk(!bus_oe && !strobe_o && !xfer_busy, "R8 abort in send",
            int'(bus_oe | strobe_o | xfer_busy), 0);
        repeat (4) @(negedge clk);
        chk(!strobe_o && !bus_oe, "R8 stays idle after abort", int'(strobe_o | bus_oe), 0);

        for (int i = 0; i < 256; i++) begin
            do_send(8'(i), (i % 17) == 0);
            do_recv(8'(i), 1'b0);
            do_recv(8'(255 - i), 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule